// File: doc/BRIEF.md
# Serial Flash Read-Command Responder

This block is the device side of a single-I/O serial flash interface that answers only two commands: a data read and an identification read. A host selects the device by pulling chip select low, shifts an 8-bit opcode in on the data input line, and for a data read follows it with a 24-bit byte address. The block then streams bytes out on the data output line. For a data read the bytes come from a small internal memory array, and the address advances after every byte. For an identification read the bytes are a fixed identity sequence. The output line is tri-stated, so the block presents it as a data bit plus an output-enable.

The serial pins are oversampled by the block's own clock. They pass through a synchronizer and an edge detector, so all state lives in a single clock domain with a synchronous active-low reset. The serial clock must therefore run well below the system clock: each serial clock half period must last at least SYNC_STAGES + 2 system clock cycles. A busy input tells the block that an erase or program cycle is running. A command whose opcode completes while busy is high is discarded, and the block produces no output for it.

The array holds DEPTH bytes, where DEPTH is a power of two. Only the low log2(DEPTH) bits of the 24-bit address are used. The array content is a fixed computed pattern.

Top module: `spi_rd_responder`

## Requirements
- R1: After reset, and within SYNC_STAGES+1 clock cycles of chip select going high, the output enable is 0. It stays 0 while chip select is high.
- R2: Input bits on the data input are taken on rising serial clock edges, most significant bit first. Opcode 8'h03 selects the data read and opcode 8'h9F selects the identification read.
- R3: The output enable stays 0 during the 8 opcode bits and the 24 address bits.
- R4: For a data read, the first output bit is driven on the falling edge that follows the last address bit. Each byte is sent most significant bit first, and the data output changes only on falling serial clock edges. The array byte at index i is (i*29 + 165) mod 256.
- R5: After each complete output byte, the array index increases by one. The starting index is the 24-bit address modulo DEPTH, and any index can be the start.
- R6: After index DEPTH-1 has been sent, output continues at index 0, with no limit on the number of bytes.
- R7: Chip select going high ends the command at any bit position, including mid-byte. The next selection starts again with a fresh opcode.
- R8: If busy_i is high when the last opcode bit is taken, the command is ignored: the output enable stays 0 until chip select goes high.
- R9: The identification read sends MFR_ID, then DEV_ID bits 15:8, then DEV_ID bits 7:0, then UID_LEN unique-ID bytes of value 8'hC0 + j (j from 0). After the last unique-ID byte the sequence starts again at MFR_ID.
- R10: Any other opcode is ignored: the output enable stays 0 until chip select goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | High while an erase or program cycle is in progress |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_din | input | 1 | Serial data from the host (opcode and address) |
| spi_dout | output | 1 | Serial data to the host; meaningful only when spi_dout_oe is 1 |
| spi_dout_oe | output | 1 | Output enable for the tri-stated data output line |

## Verification
Some properties hold on every cycle, and the inline assertions check those: the output stays disabled while deselected, during opcode and address shifting, and in the discard state. The output enable is never raised outside the two output states. The data output changes only on a detected falling edge, and the array index steps by exactly one at every byte boundary. Other behaviour depends on the stimulus, and only the bench scenarios show it: the byte values at a given address, the wrap from the top index to zero, truncation of the upper address bits, the order of the identity sequence and its restart, a mid-byte abort followed by a clean new command, and rejection under busy or for an unknown opcode. The bench covers these with directed cases and seeded random reads.

// File: rtl/flash_pkg.sv
// Shared definitions for the serial flash read responder.
// Assumes: opcodes are 8 bits and addresses are 24 bits, both sent MSB first.
package flash_pkg;

    typedef enum logic [2:0] {
        ST_CMD,   // shifting the opcode in
        ST_ADDR,  // shifting the 24-bit address in
        ST_DATA,  // streaming array bytes out
        ST_ID,    // streaming identity bytes out
        ST_SKIP   // command discarded, wait for deselect
    } rsp_state_t;

    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_RDID = 8'h9F;

    localparam logic [4:0] CMD_LAST  = 5'd7;   // index of the last opcode bit
    localparam logic [4:0] ADDR_LAST = 5'd23;  // index of the last address bit

    // Fixed content of the array cell at index idx.
    function automatic logic [7:0] cell_value(input int unsigned idx);
        return 8'(idx * 29 + 165);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Synchronizes the three serial input pins into the clk domain and reports
// serial clock edges as one-cycle pulses.
// Assumes: each serial clock level lasts at least STAGES+2 clk cycles.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic din_i,
    output logic cs_hi_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic din_o
);
    // Bit order in every stage: {cs_n, sck, din}.
    localparam logic [2:0] IDLE_PINS = 3'b100;

    logic [STAGES-1:0][2:0] pipe;
    logic                   sck_prev;
    logic [2:0]             pins;

    assign pins = pipe[STAGES-1];

    // Purpose: shift the raw pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{IDLE_PINS}};
        else        pipe <= {pipe[STAGES-2:0], {cs_n_i, sck_i, din_i}};
    end

    // Purpose: remember the last synchronized serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= pins[1];
    end

    assign cs_hi_o    = pins[2];
    assign sck_rise_o = pins[1] & ~sck_prev;
    assign sck_fall_o = ~pins[1] & sck_prev;
    assign din_o      = pins[0];

endmodule

// File: rtl/flash_array.sv
// Read-only byte array holding a computed pattern; combinational read.
// Assumes: DEPTH is a power of two and small enough to elaborate as a mux.
module flash_array #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr_i,
    output logic [7:0]    data_o
);
    import flash_pkg::*;

    logic [7:0] cells [DEPTH];

    // Purpose: build each cell from the fixed pattern function.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign cells[i] = cell_value(i);
    end

    assign data_o = cells[addr_i];

endmodule

// File: rtl/id_rom.sv
// Returns one byte of the identity sequence: manufacturer, device high,
// device low, then unique-ID bytes 8'hC0 + j.
// Assumes: idx_i is below 3 + UID_LEN.
module id_rom #(
    parameter logic [7:0]  MFR_ID  = 8'h5A,
    parameter logic [15:0] DEV_ID  = 16'h7116,
    parameter int          UID_LEN = 4,
    parameter int          IW      = $clog2(3 + UID_LEN)
) (
    input  logic [IW-1:0] idx_i,
    output logic [7:0]    data_o
);
    // Purpose: select the identity byte for the current position.
    always_comb begin
        if (idx_i == IW'(0))      data_o = MFR_ID;
        else if (idx_i == IW'(1)) data_o = DEV_ID[15:8];
        else if (idx_i == IW'(2)) data_o = DEV_ID[7:0];
        else                      data_o = 8'hC0 + 8'(idx_i - IW'(3));
    end

endmodule

// File: rtl/spi_rd_responder.sv
// Device side of a single-I/O serial flash answering the data read (03h) and
// identification (9Fh) commands. Pins are oversampled by clk. Input bits are
// taken on serial clock rising edges and output bits are driven on falling
// edges. Deselect aborts at any point.
// Assumes: DEPTH is a power of two; each serial clock half period lasts at
// least SYNC_STAGES+2 clk cycles.
module spi_rd_responder #(
    parameter int          DEPTH       = 64,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  MFR_ID      = 8'h5A,
    parameter logic [15:0] DEV_ID      = 16'h7116,
    parameter int          UID_LEN     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_din,
    output logic spi_dout,
    output logic spi_dout_oe
);
    import flash_pkg::*;

    localparam int AW     = $clog2(DEPTH);
    localparam int ID_LEN = 3 + UID_LEN;
    localparam int IW     = $clog2(ID_LEN);

    rsp_state_t    state;
    logic [22:0]   in_sr;
    logic [4:0]    bit_cnt;
    logic [2:0]    obit;
    logic [AW-1:0] addr;
    logic [IW-1:0] id_idx;
    logic          cs_hi, sck_rise, sck_fall, din;
    logic [7:0]    opcode;
    logic [7:0]    mem_byte, id_byte;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (spi_cs_n),
        .sck_i     (spi_sck),
        .din_i     (spi_din),
        .cs_hi_o   (cs_hi),
        .sck_rise_o(sck_rise),
        .sck_fall_o(sck_fall),
        .din_o     (din)
    );

    flash_array #(.DEPTH(DEPTH), .AW(AW)) i_array (
        .addr_i(addr),
        .data_o(mem_byte)
    );

    id_rom #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .UID_LEN(UID_LEN), .IW(IW)) i_id (
        .idx_i (id_idx),
        .data_o(id_byte)
    );

    assign opcode = {in_sr[6:0], din};

    // Purpose: command state machine, input shifting, output bit drive and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_CMD;
            in_sr       <= '0;
            bit_cnt     <= '0;
            obit        <= '0;
            addr        <= '0;
            id_idx      <= '0;
            spi_dout    <= 1'b0;
            spi_dout_oe <= 1'b0;
        end else if (cs_hi) begin
            state       <= ST_CMD;
            bit_cnt     <= '0;
            obit        <= '0;
            spi_dout    <= 1'b0;
            spi_dout_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_CMD: if (sck_rise) begin
                    in_sr   <= {in_sr[21:0], din};
                    bit_cnt <= bit_cnt + 5'd1;
                    if (bit_cnt == CMD_LAST) begin
                        bit_cnt <= '0;
                        obit    <= '0;
                        id_idx  <= '0;
                        if (busy_i)                  state <= ST_SKIP;
                        else if (opcode == OPC_READ) state <= ST_ADDR;
                        else if (opcode == OPC_RDID) state <= ST_ID;
                        else                         state <= ST_SKIP;
                    end
                end
                ST_ADDR: if (sck_rise) begin
                    in_sr   <= {in_sr[21:0], din};
                    bit_cnt <= bit_cnt + 5'd1;
                    if (bit_cnt == ADDR_LAST) begin
                        addr  <= AW'({in_sr, din});
                        state <= ST_DATA;
                    end
                end
                ST_DATA: if (sck_fall) begin
                    spi_dout    <= mem_byte[3'd7 - obit];
                    spi_dout_oe <= 1'b1;
                    obit        <= obit + 3'd1;
                    if (obit == 3'd7) addr <= addr + AW'(1);
                end
                ST_ID: if (sck_fall) begin
                    spi_dout    <= id_byte[3'd7 - obit];
                    spi_dout_oe <= 1'b1;
                    obit        <= obit + 3'd1;
                    if (obit == 3'd7)
                        id_idx <= (id_idx == IW'(ID_LEN - 1)) ? '0 : id_idx + IW'(1);
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !spi_dout_oe);

    a_r3_quiet_while_shifting_in: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD || state == ST_ADDR) |-> !spi_dout_oe);

    a_r4_dout_moves_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_hi) |=> $stable(spi_dout));

    a_r5_index_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !cs_hi && sck_fall && obit == 3'd7)
        |=> (addr == $past(addr) + AW'(1)));

    a_r8_discard_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !spi_dout_oe);

    a_r9_drive_only_in_output_states: assert property (@(posedge clk) disable iff (!rst_n)
        spi_dout_oe |-> (state == ST_DATA || state == ST_ID));

endmodule

// File: tb/test_spi_rd_responder.sv
// Bench: directed corner cases plus seeded random reads, with expected bytes
// computed from the requirement formulas.
module test_spi_rd_responder;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;   // clk cycles per serial clock half period
    localparam int DEPTH      = 64;
    localparam int UID_LEN    = 4;
    localparam int ID_LEN     = 3 + UID_LEN;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n, busy, cs_n, sck, din;
    logic dout, dout_oe;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    spi_rd_responder #(.DEPTH(DEPTH), .UID_LEN(UID_LEN)) i_spi_rd_responder (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .spi_cs_n(cs_n),
        .spi_sck(sck), .spi_din(din), .spi_dout(dout), .spi_dout_oe(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_cell(input int unsigned a);
        return 8'((a % DEPTH) * 29 + 165);
    endfunction

    function automatic logic [7:0] exp_id(input int unsigned k);
        int unsigned p = k % ID_LEN;
        if (p == 0) return 8'h5A;
        if (p == 1) return 8'h71;
        if (p == 2) return 8'h16;
        return 8'hC0 + 8'(p - 3);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0; sck = 1'b0; din = 1'b0;
        tick(HALF);
    endtask

    task automatic desel();
        cs_n = 1'b1; sck = 1'b0;
        tick(2 * HALF);
    endtask

    // Send n bits MSB first; counts cycles with output enabled (R3 quiet).
    task automatic send_bits(input logic [31:0] val, input int n, inout int oe_seen);
        for (int i = n - 1; i >= 0; i--) begin
            din = val[i];
            tick(HALF);
            if (dout_oe) oe_seen++;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    // Clock n bits in, sampling the output just before each rising edge.
    task automatic recv_bits(input int n, output logic [7:0] b, inout int oe_missing);
        b = '0;
        for (int i = n - 1; i >= 0; i--) begin
            tick(HALF);
            b[i] = dout;
            if (!dout_oe) oe_missing++;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic do_read(input logic [23:0] a, input int nbytes, input string req);
        int quiet = 0, miss = 0;
        logic [7:0] b;
        sel();
        send_bits(32'h03, 8, quiet);
        send_bits({8'h0, a}, 24, quiet);
        check("R3", "output enabled during opcode/address", quiet, 0);
        for (int k = 0; k < nbytes; k++) begin
            recv_bits(8, b, miss);
            check(req, $sformatf("read byte %0d from %h", k, a), b, exp_cell(a + k));
        end
        check("R4", "output enable missing during data", miss, 0);
        desel();
    endtask

    task automatic do_id(input int nbytes);
        int quiet = 0, miss = 0;
        logic [7:0] b;
        sel();
        send_bits(32'h9F, 8, quiet);
        check("R3", "output enabled during id opcode", quiet, 0);
        for (int k = 0; k < nbytes; k++) begin
            recv_bits(8, b, miss);
            check("R9", $sformatf("id byte %0d", k), b, exp_id(k));
        end
        check("R9", "output enable missing during id", miss, 0);
        desel();
    endtask

    // Opcode that must leave the output off (busy or unknown).
    task automatic do_silent(input logic [7:0] opc, input string req);
        int quiet = 0, seen = 0;
        logic [7:0] b;
        sel();
        send_bits({24'h0, opc}, 8, quiet);
        send_bits(32'h0000_0012, 24, seen);
        for (int k = 0; k < 2; k++) begin
            tick(HALF);
            if (dout_oe) seen++;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        b = 8'(seen);
        check(req, $sformatf("output enabled for ignored opcode %h", opc), b, 0);
        desel();
    endtask

    initial begin
        tick(WATCHDOG);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int quiet, miss;
        logic [7:0] b;
        void'($urandom(32'd1234));
        rst_n = 1'b0; busy = 1'b0; cs_n = 1'b1; sck = 1'b0; din = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        check("R1", "output enable after reset", dout_oe, 0);

        // R2/R4: plain reads at a few addresses
        do_read(24'h000000, 3, "R4");
        do_read(24'h000015, 2, "R4");
        // R5: upper address bits beyond DEPTH are dropped
        do_read(24'hAB0021, 2, "R5");
        // R6: wrap from the top index to zero
        do_read(24'h00003E, 4, "R6");
        do_read(24'hFFFFFF, 3, "R6");
        // R9: identity sequence with restart
        do_id(ID_LEN + 2);

        // R7: abort mid-byte, then a fresh command must work
        quiet = 0; miss = 0;
        sel();
        send_bits(32'h03, 8, quiet);
        send_bits(32'h000010, 24, quiet);
        recv_bits(8, b, miss);
        check("R7", "byte before abort", b, exp_cell(24'h10));
        recv_bits(3, b, miss);
        cs_n = 1'b1;
        tick(4);
        check("R7", "output enable after mid-byte abort", dout_oe, 0);
        check("R1", "output enable while deselected", dout_oe, 0);
        tick(2 * HALF);
        do_read(24'h000020, 2, "R7");

        // R8: busy rejects both commands
        busy = 1'b1;
        do_silent(8'h03, "R8");
        do_silent(8'h9F, "R8");
        busy = 1'b0;
        do_read(24'h000005, 1, "R8");

        // R10: unknown opcodes
        do_silent(8'h0B, "R10");
        do_silent(8'hF9, "R10");

        // Random reads and identity reads
        for (int it = 0; it < 12; it++) begin
            logic [23:0] a = 24'($urandom);
            int n = 1 + int'($urandom % 4);
            if ($urandom % 4 == 0) do_id(n);
            else                   do_read(a, n, "R5");
        end

        finish_run();
    end

endmodule